// File: doc/BRIEF.md
# Bus Memory Protection Gate

This block stands between bus masters and a single memory target and decides, per address region, whether a read or a write may go through. Software programs up to `NRGN` regions through a small register port. Each region has an inclusive lower and upper address bound, an enable bit, a read-allowed bit and a write-allowed bit. A privileged master ID can be named that may write into write-protected regions, for example so that a debug agent can patch code.

A control bit chooses how reads are handled. In the fast mode the read goes to memory in the same cycle the request is accepted, and the permission decision is made alongside it. A read that turns out to be forbidden gets its data replaced by zero and is flagged as an error. In the safe mode the decision comes first, and only permitted reads reach the memory. The safe mode costs one cycle but keeps targets with read side effects, such as FIFOs, from being touched. Writes always wait for the decision.

Every refused access returns an error on the master side. The first refusal that occurs while the fault flag is clear records its address, master ID, direction and size, and raises an interrupt that stays set until software clears it.

Top module: `mpg_gate`

## Requirements
- R1: With the safe-read bit (CTRL bit0) at 0, an accepted read drives `mem_req` with `mem_we` low in the cycle of acceptance, and `m_rvalid` rises in the following cycle.
- R2: A read refused in fast mode still reaches memory once, but answers with `m_err`=1 and `m_rdata`=0.
- R3: With CTRL bit0 at 1, no memory request is made in the acceptance cycle. A permitted read reaches memory one cycle later and answers two cycles after acceptance. A refused read never reaches memory.
- R4: A write reaches memory one cycle after acceptance, and only if it is permitted. It answers two cycles after acceptance, and a refused write leaves the memory word unchanged.
- R5: When the privileged-ID enable (CTRL bit1) is 1 and `m_id` equals CTRL bits [8 +: ID_W], a write is permitted whatever the region's write bit says. Reads get no such bypass.
- R6: Region k occupies word addresses 0x10+4k (base), 0x11+4k (limit) and 0x12+4k (attributes: bit0 enable, bit1 read allowed, bit2 write allowed). An address matches when base <= addr <= limit and the region is enabled. The lowest-numbered match decides, and an address with no match is permitted.
- R7: A refused access answers with `m_err`=1, and a permitted access answers with `m_err`=0.
- R8: On a refusal while the fault flag (STAT 0x01 bit0) is clear, the gate stores the address in FADDR (0x02) and stores in FDET (0x03) the master ID in bits [ID_W-1:0], the direction in bit16 (1 = write) and the size in bits [25:24]. The flag and `irq` then stay set, with the record frozen, until software writes 1 to STAT bit0.
- R9: After reset, CTRL, STAT and every region's attributes read 0, `irq` is 0 and `m_ready` is 1.
- R10: Only one transaction is in flight at a time. `m_ready` is low from acceptance through the response cycle, and exactly one response cycle is given per request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 1 | Master request |
| m_we | input | 1 | Master write (1) or read (0) |
| m_addr | input | ADDR_W | Master address |
| m_wdata | input | DATA_W | Master write data |
| m_size | input | 2 | Access size code |
| m_id | input | ID_W | Requesting master ID |
| m_ready | output | 1 | Gate can accept a request |
| m_rvalid | output | 1 | Response valid |
| m_err | output | 1 | Response is an error |
| m_rdata | output | DATA_W | Read data (zero when refused) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_size | output | 2 | Memory access size |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after a read request |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Sticky fault interrupt |

## Verification
The assertions check the timing rules on every cycle. In safe mode no memory request appears in the acceptance cycle. Memory writes come exactly one cycle after acceptance. Error responses carry zero data, a fast read answers in the next cycle, and the fault flag and record hold until they are cleared. Only the bench scenarios can show that each permit or refuse decision is right, because that depends on region overlap, inclusive bounds, the privileged-ID bypass and memory contents. The same holds for the presence or absence of side-effect reads and for the exact contents of the fault record.

// File: rtl/mpg_pkg.sv
package mpg_pkg;

    localparam int CFG_DW = 32;

    // register word indices
    localparam int IX_CTRL  = 'h00;
    localparam int IX_STAT  = 'h01;
    localparam int IX_FADDR = 'h02;
    localparam int IX_FDET  = 'h03;
    localparam int IX_RGN0  = 'h10;
    localparam int RGN_STRIDE = 4;

    // fault detail field positions
    localparam int FDET_DIR_BIT = 16;
    localparam int FDET_SZ_LSB  = 24;
    localparam int CTRL_ID_LSB  = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RESP  = 2'd2
    } gate_state_e;

    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
        logic en;
    } rgn_attr_t;

    function automatic logic addr_inside(input logic [31:0] a,
                                         input logic [31:0] lo,
                                         input logic [31:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic logic grant(input rgn_attr_t at, input logic we,
                                   input logic priv);
        return we ? (at.wr_ok || priv) : at.rd_ok;
    endfunction

endpackage

// File: rtl/mpg_region_check.sv
module mpg_region_check
    import mpg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ID_W   = 4,
    parameter int NRGN   = 4
) (
    input  logic                        ck_we,
    input  logic [ADDR_W-1:0]           ck_addr,
    input  logic [ID_W-1:0]             ck_id,
    input  logic [NRGN-1:0][ADDR_W-1:0] rgn_base,
    input  logic [NRGN-1:0][ADDR_W-1:0] rgn_limit,
    input  rgn_attr_t [NRGN-1:0]        rgn_attr,
    input  logic                        priv_en,
    input  logic [ID_W-1:0]             priv_id,
    output logic                        allow
);

    logic [NRGN-1:0] hit;
    logic            priv;

    assign priv = priv_en && (ck_id == priv_id);

    for (genvar g = 0; g < NRGN; g++) begin : g_hit
        assign hit[g] = rgn_attr[g].en &&
                        addr_inside(32'(ck_addr), 32'(rgn_base[g]), 32'(rgn_limit[g]));
    end

    // walk from the top down so the lowest matching region writes last
    always_comb begin
        allow = 1'b1;
        for (int i = NRGN - 1; i >= 0; i--) begin
            if (hit[i]) allow = grant(rgn_attr[i], ck_we, priv);
        end
    end

endmodule

// File: rtl/mpg_cfg_regs.sv
module mpg_cfg_regs
    import mpg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ID_W   = 4,
    parameter int NRGN   = 4,
    parameter int CFG_AW = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_wr,
    input  logic [CFG_AW-1:0]           cfg_addr,
    input  logic [CFG_DW-1:0]           cfg_wdata,
    output logic [CFG_DW-1:0]           cfg_rdata,
    input  logic                        flt_log,
    input  logic [ADDR_W-1:0]           flt_addr,
    input  logic [ID_W-1:0]             flt_id,
    input  logic                        flt_we,
    input  logic [1:0]                  flt_size,
    output logic                        spec_off,
    output logic                        priv_en,
    output logic [ID_W-1:0]             priv_id,
    output logic [NRGN-1:0][ADDR_W-1:0] rgn_base,
    output logic [NRGN-1:0][ADDR_W-1:0] rgn_limit,
    output rgn_attr_t [NRGN-1:0]        rgn_attr,
    output logic                        irq
);

    logic              flag_q;
    logic [ADDR_W-1:0] faddr_q;
    logic [ID_W-1:0]   fid_q;
    logic              fwe_q;
    logic [1:0]        fsz_q;
    logic              clr_hit;
    logic              unused_cfg_bits;

    assign unused_cfg_bits = ^cfg_wdata;

    function automatic logic sel(input logic [CFG_AW-1:0] a, input int ix);
        return a == CFG_AW'(ix);
    endfunction

    assign clr_hit = cfg_wr && sel(cfg_addr, IX_STAT) && cfg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            spec_off <= 1'b0;
            priv_en  <= 1'b0;
            priv_id  <= '0;
        end else if (cfg_wr && sel(cfg_addr, IX_CTRL)) begin
            spec_off <= cfg_wdata[0];
            priv_en  <= cfg_wdata[1];
            priv_id  <= cfg_wdata[CTRL_ID_LSB +: ID_W];
        end
    end

    // first-fault capture, held until software clears the flag
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            faddr_q <= '0;
            fid_q   <= '0;
            fwe_q   <= 1'b0;
            fsz_q   <= '0;
        end else if (clr_hit) begin
            flag_q <= 1'b0;
        end else if (flt_log && !flag_q) begin
            flag_q  <= 1'b1;
            faddr_q <= flt_addr;
            fid_q   <= flt_id;
            fwe_q   <= flt_we;
            fsz_q   <= flt_size;
        end
    end

    assign irq = flag_q;

    for (genvar g = 0; g < NRGN; g++) begin : g_rgn
        localparam int IXB = IX_RGN0 + RGN_STRIDE * g;
        always_ff @(posedge clk) begin
            if (rst) begin
                rgn_base[g]  <= '0;
                rgn_limit[g] <= '0;
                rgn_attr[g]  <= '0;
            end else if (cfg_wr) begin
                if (sel(cfg_addr, IXB))     rgn_base[g]  <= cfg_wdata[ADDR_W-1:0];
                if (sel(cfg_addr, IXB + 1)) rgn_limit[g] <= cfg_wdata[ADDR_W-1:0];
                if (sel(cfg_addr, IXB + 2)) rgn_attr[g]  <= rgn_attr_t'(cfg_wdata[2:0]);
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (sel(cfg_addr, IX_CTRL)) begin
            cfg_rdata[0] = spec_off;
            cfg_rdata[1] = priv_en;
            cfg_rdata[CTRL_ID_LSB +: ID_W] = priv_id;
        end
        if (sel(cfg_addr, IX_STAT))  cfg_rdata[0] = flag_q;
        if (sel(cfg_addr, IX_FADDR)) cfg_rdata[ADDR_W-1:0] = faddr_q;
        if (sel(cfg_addr, IX_FDET)) begin
            cfg_rdata[ID_W-1:0] = fid_q;
            cfg_rdata[FDET_DIR_BIT] = fwe_q;
            cfg_rdata[FDET_SZ_LSB +: 2] = fsz_q;
        end
        for (int i = 0; i < NRGN; i++) begin
            if (sel(cfg_addr, IX_RGN0 + RGN_STRIDE * i))     cfg_rdata[ADDR_W-1:0] = rgn_base[i];
            if (sel(cfg_addr, IX_RGN0 + RGN_STRIDE * i + 1)) cfg_rdata[ADDR_W-1:0] = rgn_limit[i];
            if (sel(cfg_addr, IX_RGN0 + RGN_STRIDE * i + 2)) cfg_rdata[2:0] = rgn_attr[i];
        end
    end

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_hit) |=> flag_q);
    p_record_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        flag_q |=> ($stable(faddr_q) && $stable(fid_q) && $stable(fwe_q) && $stable(fsz_q)));

endmodule

// File: rtl/mpg_gate.sv
module mpg_gate
    import mpg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int ID_W   = 4,
    parameter int NRGN   = 4,
    parameter int CFG_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              m_req,
    input  logic              m_we,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    input  logic [1:0]        m_size,
    input  logic [ID_W-1:0]   m_id,
    output logic              m_ready,
    output logic              m_rvalid,
    output logic              m_err,
    output logic [DATA_W-1:0] m_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [1:0]        mem_size,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              irq
);

    gate_state_e st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [1:0]        size_q;
    logic              we_q;
    logic              allow_q;

    logic spec_off, priv_en;
    logic [ID_W-1:0] priv_id;
    logic [NRGN-1:0][ADDR_W-1:0] rgn_base, rgn_limit;
    rgn_attr_t [NRGN-1:0] rgn_attr;
    logic chk_allow, accept, spec_rd;

    mpg_cfg_regs #(
        .ADDR_W(ADDR_W), .ID_W(ID_W), .NRGN(NRGN), .CFG_AW(CFG_AW)
    ) u_regs (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .flt_log(accept && !chk_allow), .flt_addr(m_addr), .flt_id(m_id),
        .flt_we(m_we), .flt_size(m_size),
        .spec_off(spec_off), .priv_en(priv_en), .priv_id(priv_id),
        .rgn_base(rgn_base), .rgn_limit(rgn_limit), .rgn_attr(rgn_attr),
        .irq(irq)
    );

    mpg_region_check #(
        .ADDR_W(ADDR_W), .ID_W(ID_W), .NRGN(NRGN)
    ) u_check (
        .ck_we(m_we), .ck_addr(m_addr), .ck_id(m_id),
        .rgn_base(rgn_base), .rgn_limit(rgn_limit), .rgn_attr(rgn_attr),
        .priv_en(priv_en), .priv_id(priv_id),
        .allow(chk_allow)
    );

    assign accept  = m_req && (st_q == ST_IDLE);
    assign spec_rd = accept && !m_we && !spec_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            allow_q <= 1'b0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            size_q  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (accept) begin
                    allow_q <= chk_allow;
                    we_q    <= m_we;
                    addr_q  <= m_addr;
                    wdata_q <= m_wdata;
                    size_q  <= m_size;
                    st_q    <= spec_rd ? ST_RESP : ST_ISSUE;
                end
                ST_ISSUE: st_q <= ST_RESP;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    // memory side: speculative reads leave straight from the request pins
    assign mem_req   = spec_rd || ((st_q == ST_ISSUE) && allow_q);
    assign mem_we    = (st_q == ST_ISSUE) && we_q;
    assign mem_addr  = (st_q == ST_IDLE) ? m_addr : addr_q;
    assign mem_size  = (st_q == ST_IDLE) ? m_size : size_q;
    assign mem_wdata = wdata_q;

    // master side
    assign m_ready  = (st_q == ST_IDLE);
    assign m_rvalid = (st_q == ST_RESP);
    assign m_err    = (st_q == ST_RESP) && !allow_q;
    assign m_rdata  = ((st_q == ST_RESP) && allow_q && !we_q) ? mem_rdata : '0;

    p_no_early_read_r3: assert property (@(posedge clk) disable iff (rst)
        (m_ready && spec_off) |-> !mem_req);
    p_write_after_check_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> $past(accept && m_we));
    p_withhold_data_r2: assert property (@(posedge clk) disable iff (rst)
        m_err |-> (m_rdata == '0));
    p_fast_reply_r1: assert property (@(posedge clk) disable iff (rst)
        spec_rd |=> m_rvalid);
    p_one_reply_r10: assert property (@(posedge clk) disable iff (rst)
        m_rvalid |=> !m_rvalid);

endmodule

// File: tb/tb_mpg_gate.sv
module tb_mpg_gate;
    localparam int CLK_PERIOD = 10;
    localparam int NRGN = 4;

    logic clk = 0, rst = 1;
    logic m_req = 0, m_we = 0;
    logic [15:0] m_addr = 0;
    logic [31:0] m_wdata = 0;
    logic [1:0]  m_size = 0;
    logic [3:0]  m_id = 0;
    logic m_ready, m_rvalid, m_err;
    logic [31:0] m_rdata;
    logic mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [1:0]  mem_size;
    logic [31:0] mem_rdata = 0;
    logic cfg_wr = 0;
    logic [5:0] cfg_addr = 0;
    logic [31:0] cfg_wdata = 0;
    logic [31:0] cfg_rdata;
    logic irq;

    int nchk = 0, nerr = 0, rd_cnt = 0;
    logic [31:0] mem [256];

    // shadow configuration
    logic [15:0] sh_base [NRGN];
    logic [15:0] sh_lim  [NRGN];
    logic [2:0]  sh_attr [NRGN];
    logic sh_spec_off = 0, sh_priv_en = 0, sh_flag = 0;
    logic [3:0] sh_priv_id = 0;
    logic [15:0] sh_faddr;
    logic [31:0] sh_fdet;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpg_gate dut (
        .clk(clk), .rst(rst),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_size(m_size), .m_id(m_id), .m_ready(m_ready), .m_rvalid(m_rvalid),
        .m_err(m_err), .m_rdata(m_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_size(mem_size), .mem_rdata(mem_rdata),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq(irq)
    );

    // memory target: one-cycle read latency, counts read requests
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else begin
                mem_rdata <= mem[mem_addr[7:0]];
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic exp_allow(input logic [15:0] a, input logic we, input logic [3:0] id);
        for (int i = 0; i < NRGN; i++) begin
            if (sh_attr[i][0] && a >= sh_base[i] && a <= sh_lim[i])
                return we ? (sh_attr[i][2] || (sh_priv_en && id == sh_priv_id)) : sh_attr[i][1];
        end
        return 1'b1;
    endfunction

    task automatic cfg_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic set_ctrl(input logic so, input logic pe, input logic [3:0] pid);
        cfg_write(6'h00, {20'd0, pid, 6'd0, pe, so});
        sh_spec_off = so; sh_priv_en = pe; sh_priv_id = pid;
    endtask

    task automatic set_rgn(input int k, input logic [15:0] b, input logic [15:0] l, input logic [2:0] at);
        cfg_write(6'(16 + 4*k), {16'd0, b});
        cfg_write(6'(17 + 4*k), {16'd0, l});
        cfg_write(6'(18 + 4*k), {29'd0, at});
        sh_base[k] = b; sh_lim[k] = l; sh_attr[k] = at;
    endtask

    task automatic txn(input logic we, input logic [15:0] a, input logic [31:0] wd,
                       input logic [1:0] sz, input logic [3:0] id);
        logic ex_allow, ex_spec, early;
        logic [31:0] old;
        int rd0, lat;
        ex_allow = exp_allow(a, we, id);
        ex_spec  = !we && !sh_spec_off;
        old = mem[a[7:0]];
        @(negedge clk);
        chk("R10 ready before request", {31'd0, m_ready}, 1);
        m_req = 1; m_we = we; m_addr = a; m_wdata = wd; m_size = sz; m_id = id;
        #1 early = mem_req && !mem_we;
        rd0 = rd_cnt;
        @(posedge clk);
        @(negedge clk);
        m_req = 0;
        chk("R10 ready low after accept", {31'd0, m_ready}, 0);
        lat = 1;
        while (!m_rvalid && lat < 6) begin
            @(negedge clk);
            lat++;
        end
        if (ex_spec) chk("R1 fast read latency", lat, 1);
        else if (we) chk("R4 write latency", lat, 2);
        else         chk("R3 checked read latency", lat, 2);
        if (ex_spec) chk("R1 read issued at accept", {31'd0, early}, 1);
        else         chk("R3 nothing issued at accept", {31'd0, early}, 0);
        chk("R7 error flag", {31'd0, m_err}, {31'd0, !ex_allow});
        if (!we) begin
            chk("R2 read data", m_rdata, ex_allow ? old : 32'd0);
            if (ex_spec) chk("R2 memory read count", rd_cnt - rd0, 1);
            else         chk("R3 memory read count", rd_cnt - rd0, ex_allow ? 1 : 0);
        end else begin
            chk("R4 memory word after write", mem[a[7:0]], ex_allow ? wd : old);
        end
        if (!ex_allow && !sh_flag) begin
            sh_flag = 1; sh_faddr = a;
            sh_fdet = 32'(id) | (32'(we) << 16) | (32'(sz) << 24);
        end
        chk("R8 irq level", {31'd0, irq}, {31'd0, sh_flag});
    endtask

    task automatic check_fault();
        logic [31:0] d;
        if (sh_flag) begin
            cfg_read(6'h01, d); chk("R8 flag set", d, 1);
            cfg_read(6'h02, d); chk("R8 fault address", d, {16'd0, sh_faddr});
            cfg_read(6'h03, d); chk("R8 fault details", d, sh_fdet);
            cfg_write(6'h01, 32'd1);
            sh_flag = 0;
            #1 chk("R8 irq cleared", {31'd0, irq}, 0);
        end
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) mem[i] = 32'h5A5A_0000 ^ (i * 32'h0101_0103);
        for (int i = 0; i < NRGN; i++) begin
            sh_base[i] = 0; sh_lim[i] = 0; sh_attr[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 ready in reset", {31'd0, m_ready}, 1);
        chk("R9 irq in reset", {31'd0, irq}, 0);
        rst = 0;
        cfg_read(6'h00, d); chk("R9 ctrl reset", d, 0);
        cfg_read(6'h01, d); chk("R9 stat reset", d, 0);
        cfg_read(6'h12, d); chk("R9 region attr reset", d, 0);

        // directed layout: overlap of region 0 and 1, disabled region 3
        set_rgn(0, 16'h0100, 16'h01FF, 3'b101);
        set_rgn(1, 16'h0180, 16'h02FF, 3'b011);
        set_rgn(2, 16'h0400, 16'h04FF, 3'b111);
        set_rgn(3, 16'h0500, 16'h05FF, 3'b000);
        cfg_read(6'h11, d); chk("R6 limit readback", d, 32'h01FF);

        txn(0, 16'h01FF, 0, 2'd2, 4'd1);  // R6 inclusive limit, region 0 wins; R2
        check_fault();
        txn(0, 16'h0200, 0, 2'd1, 4'd1);  // R1 allowed via region 1
        txn(1, 16'h0200, 32'hCAFE_0001, 2'd2, 4'd2);  // R4 refused write
        check_fault();
        txn(0, 16'h00FF, 0, 2'd0, 4'd3);  // R6 unmatched
        txn(0, 16'h0100, 0, 2'd0, 4'd3);  // R6 inclusive base
        txn(0, 16'h0300, 0, 2'd3, 4'd3);  // second refusal ignored while flag held: none here
        txn(0, 16'h0520, 0, 2'd0, 4'd3);  // R6 disabled region ignored
        check_fault();

        set_ctrl(1, 1, 4'd5);
        cfg_read(6'h00, d); chk("R5 ctrl readback", d, 32'h0000_0503);
        txn(0, 16'h0100, 0, 2'd2, 4'd1);  // R3 refused, no memory read
        txn(0, 16'h0250, 0, 2'd2, 4'd1);  // R3 permitted, two cycles
        txn(1, 16'h0200, 32'hBEEF_0005, 2'd2, 4'd5);  // R5 privileged write
        txn(0, 16'h0101, 0, 2'd2, 4'd5);  // R5 no read bypass
        txn(1, 16'h0210, 32'h1111_2222, 2'd1, 4'd6);  // R8 second fault not recorded
        check_fault();
        set_ctrl(1, 0, 4'd5);
        txn(1, 16'h0200, 32'hDEAD_0005, 2'd2, 4'd5);  // R5 bypass off
        check_fault();

        for (int n = 0; n < 400; n++) begin
            if (n % 50 == 0) begin
                for (int k = 0; k < NRGN; k++) begin
                    logic [15:0] b;
                    b = 16'($urandom % 32'h0C00);
                    set_rgn(k, b, b + 16'($urandom % 32'h0300), 3'($urandom));
                end
                set_ctrl(1'($urandom), 1'($urandom), 4'($urandom));
            end
            txn(1'($urandom), 16'($urandom % 32'h1000), $urandom, 2'($urandom),
                ($urandom % 4 == 0) ? sh_priv_id : 4'($urandom));
            if (n % 7 == 6) check_fault();
        end
        check_fault();

        report();
        $finish;
    end
endmodule